// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer that turns a virtual address into a physical address for the process that is running now. The virtual address is split by bit position into a page number and an in-page offset. The page number, together with the current address-space tag, is compared against every stored entry at once. On a hit, the stored frame number is placed above the unchanged offset. On a miss, a flag goes up so that an outside agent, such as a table walker, can find the mapping and write it in through the fill port.

Every entry holds a valid bit, a page number, an address-space tag and a frame number. A hit needs all three of these: the entry is valid, its page number matches, and its tag matches. Because of this, mappings from several processes can sit in the buffer together. Maintenance is decoded each cycle into one of four named operations, with a fixed priority between them: OP_IDLE, OP_FILL, OP_FLUSH_ALL and OP_FLUSH_ASID. A fill goes to the lowest-numbered free entry. When every entry is valid, a fill goes to the entry chosen by a round-robin pointer. There are two kinds of flush: one drops every entry, the other drops only the entries of a single address space.

The operation decode works as a single-cycle selector with no hold state. Each cycle it moves from OP_IDLE to whichever operation its inputs request, and it goes back to OP_IDLE in the next cycle unless a request is still present.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, lk_paddr equals the stored frame number concatenated above lk_vaddr[OFF_W-1:0], and the offset bits are passed through unchanged. When there is no hit, lk_paddr is zero.
- R2: A hit needs three things at once: an entry is valid, its page number equals lk_vaddr[VPN_W+OFF_W-1:OFF_W], and its tag equals lk_asid. An entry that matches the page but carries a different tag gives a miss.
- R3: Lookup is combinational. lk_hit, lk_miss and lk_paddr follow the request within the same cycle. While lk_req is low, lk_hit and lk_miss are both low. lk_miss is exactly lk_req with no hit.
- R4: If several valid entries match, the frame is taken from the lowest-indexed matching entry.
- R5: A fill writes into the lowest-indexed invalid entry whenever an invalid entry exists.
- R6: When all entries are valid, a fill overwrites the entry at the round-robin pointer. The pointer starts at 0, advances by one after each such overwrite, and wraps from ENTRIES-1 to 0.
- R7: flush_all clears every valid bit at one clock edge. From the next cycle on, every lookup misses.
- R8: flush_asid_en clears only the entries whose tag equals flush_asid_id. Entries of other tags keep hitting.
- R9: At most one operation takes effect per edge. flush_all wins over flush_asid_en, and flush_asid_en wins over fill_en. A lower-priority request in the same cycle is ignored.
- R10: Reset clears all valid bits and returns the round-robin pointer to 0.
- R11: A fill becomes visible to lookups from the cycle after its edge. A lookup in the same cycle as the fill sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address: page number in the upper bits, offset in the lower bits |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_paddr | output | PFN_W+OFF_W | Physical address: frame number and offset |
| fill_en | input | 1 | Write a new mapping |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_asid | input | ASID_W | Tag of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one tag |
| flush_asid_id | input | ASID_W | Tag to invalidate |

## Verification
The cycle-level properties are checked on every cycle:
- hit and miss are exclusive and both stay silent while lk_req is low;
- the offset passes through unchanged;
- a mapping filled at one edge is found in the next cycle;
- after flush_all no entry is valid;
- after a tag flush nothing of that tag can hit.

Some behaviour depends on long histories and can only be shown by the bench's scenarios. This covers which entry a fill lands in, the order in which the round-robin pointer replaces entries once the buffer is full, the choice of the lowest-indexed match among duplicates, and the way simultaneous requests are resolved. The bench sweeps a grid of page numbers and tags after each step and compares every answer with an arithmetic model of the buffer's contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE       = 2'd0,
        OP_FILL       = 2'd1,
        OP_FLUSH_ALL  = 2'd2,
        OP_FLUSH_ASID = 2'd3
    } tlb_op_e;

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tags,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tags,
    input  logic [VPN_W-1:0]               q_vpn,
    input  logic [ASID_W-1:0]              q_asid,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [ENTRIES-1:0] match_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = valid[g]
                                  && (vpn_tags[g] == q_vpn)
                                  && (asid_tags[g] == q_asid);
        end
    endgenerate

    // Scan from the top so the lowest matching index is the last assignment.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               fill_go,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic             replace_go;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : rr_q;
    assign replace_go = fill_go && !free_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (replace_go) begin
            if (rr_q == IDX_W'(ENTRIES - 1)) begin
                rr_q <= '0;
            end else begin
                rr_q <= rr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  tlb_op_e                        op,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VPN_W-1:0]               wr_vpn,
    input  logic [ASID_W-1:0]              wr_asid,
    input  logic [PFN_W-1:0]               wr_pfn,
    input  logic [ASID_W-1:0]              kill_asid,
    output logic [ENTRIES-1:0]             valid,
    output logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tags,
    output logic [ENTRIES-1:0][ASID_W-1:0] asid_tags,
    output logic [ENTRIES-1:0][PFN_W-1:0]  pfn_data
);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            logic sel;
            assign sel = (wr_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[g] <= 1'b0;
                end else begin
                    unique case (op)
                        OP_FLUSH_ALL:  valid[g] <= 1'b0;
                        OP_FLUSH_ASID: begin
                            if (asid_tags[g] == kill_asid) begin
                                valid[g] <= 1'b0;
                            end
                        end
                        OP_FILL: begin
                            if (sel) begin
                                valid[g] <= 1'b1;
                            end
                        end
                        OP_IDLE:       valid[g] <= valid[g];
                    endcase
                end
            end

            always_ff @(posedge clk) begin
                if ((op == OP_FILL) && sel) begin
                    vpn_tags[g]  <= wr_vpn;
                    asid_tags[g] <= wr_asid;
                    pfn_data[g]  <= wr_pfn;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_req,
    input  logic [VPN_W+OFF_W-1:0]  lk_vaddr,
    input  logic [ASID_W-1:0]       lk_asid,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic [PFN_W+OFF_W-1:0]  lk_paddr,
    input  logic                    fill_en,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic                    flush_all,
    input  logic                    flush_asid_en,
    input  logic [ASID_W-1:0]       flush_asid_id
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_op_e                         op_sel;
    logic [ENTRIES-1:0]              entry_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tags;
    logic [ENTRIES-1:0][ASID_W-1:0]  asid_tags;
    logic [ENTRIES-1:0][PFN_W-1:0]   pfn_data;
    logic [IDX_W-1:0]                victim_idx;
    logic [IDX_W-1:0]                hit_idx;
    logic                            cam_hit;
    logic [VPN_W-1:0]                q_vpn;
    logic [OFF_W-1:0]                q_off;

    // Operation selector: one operation per edge, fixed priority.
    always_comb begin
        if (flush_all) begin
            op_sel = OP_FLUSH_ALL;
        end else if (flush_asid_en) begin
            op_sel = OP_FLUSH_ASID;
        end else if (fill_en) begin
            op_sel = OP_FILL;
        end else begin
            op_sel = OP_IDLE;
        end
    end

    assign q_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
    assign q_off = lk_vaddr[OFF_W-1:0];

    tlb_entry_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .PFN_W   (PFN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_sel),
        .wr_idx    (victim_idx),
        .wr_vpn    (fill_vpn),
        .wr_asid   (fill_asid),
        .wr_pfn    (fill_pfn),
        .kill_asid (flush_asid_id),
        .valid     (entry_valid),
        .vpn_tags  (vpn_tags),
        .asid_tags (asid_tags),
        .pfn_data  (pfn_data)
    );

    tlb_victim_sel #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (entry_valid),
        .fill_go    (op_sel == OP_FILL),
        .victim_idx (victim_idx)
    );

    tlb_cam_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_match (
        .valid     (entry_valid),
        .vpn_tags  (vpn_tags),
        .asid_tags (asid_tags),
        .q_vpn     (q_vpn),
        .q_asid    (lk_asid),
        .hit       (cam_hit),
        .hit_idx   (hit_idx)
    );

    // Output process.
    always_comb begin
        lk_hit   = lk_req && cam_hit;
        lk_miss  = lk_req && !cam_hit;
        lk_paddr = '0;
        if (lk_hit) begin
            lk_paddr = {pfn_data[hit_idx], q_off};
        end
    end

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_req,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic [ASID_W-1:0]      lk_asid,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic [PFN_W+OFF_W-1:0] lk_paddr,
    input logic                   fill_en,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic [ASID_W-1:0]      fill_asid,
    input logic                   flush_all,
    input logic                   flush_asid_en,
    input logic [ASID_W-1:0]      flush_asid_id,
    input logic [ENTRIES-1:0]     entry_valid
);

    assert_flags_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss));

    assert_hit_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_hit != lk_miss));

    assert_offset_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    assert_flush_all_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (entry_valid == '0));

    assert_fill_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all && !flush_asid_en) |=>
            ((lk_req && (lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn))
              && (lk_asid == $past(fill_asid))) -> lk_hit));

    assert_flush_tag_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_asid_en && !flush_all) |=>
            !(lk_hit && (lk_asid == $past(flush_asid_id))));

endmodule

bind asid_tlb asid_tlb_checker #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W),
    .ASID_W  (ASID_W),
    .PFN_W   (PFN_W)
) u_asid_tlb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .lk_vaddr      (lk_vaddr),
    .lk_asid       (lk_asid),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_paddr      (lk_paddr),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_asid     (fill_asid),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .flush_asid_id (flush_asid_id),
    .entry_valid   (entry_valid)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic        lk_miss;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid_id = '0;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    // Reference model of the buffer contents.
    bit          m_v   [N];
    logic [19:0] m_vpn [N];
    logic [7:0]  m_asid[N];
    logic [19:0] m_pfn [N];
    int          m_rr;

    always #10 clk = ~clk;

    asid_tlb u_asid_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_req        (lk_req),
        .lk_vaddr      (lk_vaddr),
        .lk_asid       (lk_asid),
        .lk_hit        (lk_hit),
        .lk_miss       (lk_miss),
        .lk_paddr      (lk_paddr),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_asid     (fill_asid),
        .fill_pfn      (fill_pfn),
        .flush_all     (flush_all),
        .flush_asid_en (flush_asid_en),
        .flush_asid_id (flush_asid_id)
    );

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endtask

    task automatic model_fill(logic [19:0] v, logic [7:0] a, logic [19:0] p);
        int slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[slot] = 1'b1; m_vpn[slot] = v; m_asid[slot] = a; m_pfn[slot] = p;
    endtask

    task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual hit/miss/paddr=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one lookup and checks it in the same cycle (R3), no clock edge needed.
    task automatic probe(string tag, logic [19:0] v, logic [7:0] a, logic [11:0] off);
        logic        eh = 1'b0;
        logic [31:0] ep = '0;
        lk_req = 1'b1; lk_vaddr = {v, off}; lk_asid = a;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) begin
                eh = 1'b1; ep = {m_pfn[i], off};
            end
        end
        #2;
        check(tag, {lk_hit, lk_miss, lk_paddr}, {eh, !eh, ep});
    endtask

    task automatic sweep(string tag);
        logic [7:0] tags[3] = '{8'd3, 8'd5, 8'd9};
        for (int v = 'h100; v < 'h120; v++) begin
            for (int t = 0; t < 3; t++) begin
                @(negedge clk);
                probe(tag, 20'(v), tags[t], 12'((v * 37 + t * 1111) & 'hFFF));
            end
        end
        lk_req = 1'b0;
    endtask

    task automatic apply(bit fa, bit fae, logic [7:0] fid, bit fe,
                         logic [19:0] v, logic [7:0] a, logic [19:0] p);
        @(negedge clk);
        flush_all = fa; flush_asid_en = fae; flush_asid_id = fid;
        fill_en = fe; fill_vpn = v; fill_asid = a; fill_pfn = p;
        if (fe) probe("R11 same-cycle old contents", v, a, 12'h123);
        @(posedge clk);
        #1;
        flush_all = 1'b0; flush_asid_en = 1'b0; fill_en = 1'b0; lk_req = 1'b0;
        if (fa) model_clear_valid();
        else if (fae) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fid) m_v[i] = 1'b0;
        end else if (fe) model_fill(v, a, p);
        if (fe && !fa && !fae) begin
            @(negedge clk);
            probe("R11 next-cycle visible", v, a, 12'hFFF);
            lk_req = 1'b0;
        end
    endtask

    task automatic model_clear_valid();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R10: everything misses after reset; R3: idle request keeps flags low.
        sweep("R10 reset empty");
        @(negedge clk);
        lk_req = 1'b0; lk_vaddr = {20'h100, 12'h0}; #2;
        check("R3 idle flags", {lk_hit, lk_miss, lk_paddr}, '0);

        // R5: fill to lowest free entry; R1/R2 checked by the sweep.
        for (int i = 0; i < N; i++)
            apply(0, 0, 0, 1, 20'h100 + 20'(i), (i < 4) ? 8'd5 : 8'd9, 20'hA000 + 20'(3 * i));
        sweep("R1 R2 R5 full table");

        // R6: round-robin replacement once full.
        for (int j = 0; j < 10; j++)
            apply(0, 0, 0, 1, 20'h110 + 20'(j), (j % 3 == 0) ? 8'd3 : 8'd5, 20'hB000 + 20'(j));
        sweep("R6 round-robin replacement");

        // R8: tag flush.
        apply(0, 1, 8'd5, 0, '0, '0, '0);
        sweep("R8 flush by tag");

        // R9: flush_all beats fill.
        apply(1, 0, 0, 1, 20'h11A, 8'd9, 20'hD000);
        sweep("R9 flush_all over fill");
        apply(0, 0, 0, 1, 20'h101, 8'd3, 20'hD101);
        apply(0, 0, 0, 1, 20'h102, 8'd5, 20'hD102);
        // R9: tag flush beats fill.
        apply(0, 1, 8'd3, 1, 20'h103, 8'd9, 20'hD103);
        sweep("R9 tag flush over fill");

        // R7: flush all.
        apply(1, 0, 0, 0, '0, '0, '0);
        sweep("R7 flush all");

        // R4: duplicates, lowest index wins.
        apply(0, 0, 0, 1, 20'h105, 8'd5, 20'hC001);
        apply(0, 0, 0, 1, 20'h105, 8'd5, 20'hC002);
        sweep("R4 lowest index wins");

        // R10: reset mid-run clears entries and pointer.
        for (int i = 0; i < 6; i++) apply(0, 0, 0, 1, 20'h108 + 20'(i), 8'd9, 20'hE000 + 20'(i));
        do_reset();
        sweep("R10 reset mid-run");
        for (int i = 0; i < N + 3; i++)
            apply(0, 0, 0, 1, 20'h100 + 20'(2 * i), 8'd3, 20'hF000 + 20'(i));
        sweep("R6 R10 pointer restarts at zero");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule